// File: doc/BRIEF.md
# Asynchronous SRAM Read Sequencer

This block performs single-byte reads from a 128K x 8 asynchronous static RAM on behalf of a synchronous client. The client presents a 17-bit address with a valid/ready handshake. The sequencer drives the memory address, the two chip enables and the output enable. It waits enough clock cycles for the data to settle, registers the byte, and returns it with a one-cycle valid strobe. The memory's write enable is held inactive, because the block only reads.

All timing limits of the memory are given in nanoseconds. The clock period is a parameter, and each limit becomes a whole number of wait cycles: the rounded-up quotient, never less than one. After every access the output enable is raised for the output-float count, so that the shared data bus is released before anything else can drive it. The cycle after that gap is a hold cycle. If a new request is waiting in the hold cycle, the chip stays selected and the next access starts at once. If no request is waiting, the chip is deselected and the block waits out the deselect-float count before it is idle again.

Top module: `sram_rd_seq`

## Requirements
- R1: After reset the low-active enable is 1, the high-active enable is 0, the read enable (low active) is 1, the write enable (low active) is 1, `rd_valid` is 0 and `req_ready` is 1.
- R2: The memory is selected only with `mem_en_lo_n`=0 and `mem_en_hi`=1 together. `mem_rden_n` is 0 only while the memory is selected.
- R3: `mem_wren_n` stays 1 in every cycle.
- R4: `mem_addr` takes `req_addr` on the edge where `req_valid` and `req_ready` are both 1. It does not change while `mem_rden_n` stays 0.
- R5: Each access holds `mem_rden_n` at 0 for exactly N_ACC = max(1, ceil(max(15, 7) / CLK_NS)) cycles. `rd_valid` rises at the N_ACC-th rising edge after the accepting edge.
- R6: `rd_data` equals the byte on `mem_din` at the last cycle of the access. `rd_valid` is 1 for exactly one cycle per access.
- R7: After each access `mem_rden_n` is 1 for at least N_OEF = max(1, ceil(7 / CLK_NS)) cycles before it can go low again, and `req_ready` is 0 during that gap.
- R8: If a request is waiting when `req_ready` returns after the gap, the chip enables stay active between the two reads. The read-enable high time between the reads is then exactly N_OEF+1 cycles.
- R9: If no request is waiting in the hold cycle, the chip is deselected. `req_ready` then stays 0 for exactly N_CEF = max(1, ceil(8 / CLK_NS)) cycles before the block is idle and ready again.
- R10: `req_ready` is 1 only while `mem_rden_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS nanoseconds |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Client read request |
| req_addr | input | 17 | Byte address of the request |
| req_ready | output | 1 | Block can accept a request this cycle |
| rd_data | output | 8 | Byte returned by the last read |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` as new |
| mem_addr | output | 17 | Address pins of the memory |
| mem_en_lo_n | output | 1 | Active-low chip enable |
| mem_en_hi | output | 1 | Active-high chip enable |
| mem_rden_n | output | 1 | Active-low output enable of the memory |
| mem_wren_n | output | 1 | Active-low write enable, held inactive |
| mem_din | input | 8 | Data pins of the memory, read direction |

## Verification
The assertions assume that the client keeps `req_valid` and `req_addr` steady until the handshake completes. They also assume that the memory is the only device that drives `mem_din` while the read enable is low. The bench meets these assumptions: it changes the request only on falling edges and drops it on the falling edge after the accepting edge. Its memory model returns a byte derived from the address only once the address and the enables have been steady for 15 ns. If the pins change or are inactive, the model returns the complement of that byte, so a read that is cut short returns a wrong value.

// File: rtl/sram_rd_pkg.sv
package sram_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ACCESS  = 3'd1,
    ST_GAP     = 3'd2,
    ST_HOLD    = 3'd3,
    ST_RELEASE = 3'd4
  } rd_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Wait cycles covering a nanosecond limit: rounded up, at least one.
  function automatic int ns_to_cycles(input int ns, input int clk_ns);
    return imax(1, (ns + clk_ns - 1) / clk_ns);
  endfunction

endpackage

// File: rtl/sram_rd_timer.sv
module sram_rd_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] load,
  output logic          expire
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= load;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign expire = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_fsm.sv
module sram_rd_fsm
  import sram_rd_pkg::*;
#(
  parameter int N_ACC = 3,
  parameter int N_OEF = 2,
  parameter int N_CEF = 2,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          t_expire,
  output logic          t_start,
  output logic [CW-1:0] t_load,
  output logic          sel,
  output logic          rden,
  output logic          accept,
  output logic          capture
);

  rd_state_t state_q, state_d;
  logic      sel_q, rden_q;

  always_comb begin
    state_d = state_q;
    t_start = 1'b0;
    t_load  = '0;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        state_d = ST_ACCESS; t_start = 1'b1; t_load = CW'(N_ACC - 1);
      end
      ST_ACCESS: if (t_expire) begin
        capture = 1'b1;
        state_d = ST_GAP; t_start = 1'b1; t_load = CW'(N_OEF - 1);
      end
      ST_GAP: if (t_expire) state_d = ST_HOLD;
      ST_HOLD: begin
        t_start = 1'b1;
        if (req_valid) begin
          state_d = ST_ACCESS; t_load = CW'(N_ACC - 1);
        end else begin
          state_d = ST_RELEASE; t_load = CW'(N_CEF - 1);
        end
      end
      ST_RELEASE: if (t_expire) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      rden_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= (state_d == ST_ACCESS) || (state_d == ST_GAP) || (state_d == ST_HOLD);
      rden_q  <= (state_d == ST_ACCESS);
    end
  end

  assign req_ready = (state_q == ST_IDLE) || (state_q == ST_HOLD);
  assign accept    = req_ready && req_valid;
  assign sel       = sel_q;
  assign rden      = rden_q;

  // R9: while the bus floats after deselect, no request is taken
  assert_no_ready_after_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_q) && !sel_q) |-> !req_ready);

  // R10: handshake only with the memory output disabled
  assert_ready_with_output_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rden_q);

endmodule

// File: rtl/sram_rd_datapath.sv
module sram_rd_datapath #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] mem_din,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (accept)  mem_addr <= req_addr;
      if (capture) rd_data  <= mem_din;
      rd_valid <= capture;
    end
  end

  // R6: the strobe never spans two cycles
  assert_single_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_rd_seq.sv
module sram_rd_seq
  import sram_rd_pkg::*;
#(
  parameter int CLK_NS     = 5,
  parameter int T_ACC_NS   = 15,
  parameter int T_OE_NS    = 7,
  parameter int T_OEF_NS   = 7,
  parameter int T_CEF_NS   = 8,
  parameter int AW         = 17,
  parameter int DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [AW-1:0] mem_addr,
  output logic          mem_en_lo_n,
  output logic          mem_en_hi,
  output logic          mem_rden_n,
  output logic          mem_wren_n,
  input  logic [DW-1:0] mem_din
);

  localparam int N_ACC = ns_to_cycles(imax(T_ACC_NS, T_OE_NS), CLK_NS);
  localparam int N_OEF = ns_to_cycles(T_OEF_NS, CLK_NS);
  localparam int N_CEF = ns_to_cycles(T_CEF_NS, CLK_NS);
  localparam int N_MAX = imax(N_ACC, imax(N_OEF, N_CEF));
  localparam int CW    = (N_MAX <= 2) ? 1 : $clog2(N_MAX);
  localparam int GW    = $clog2(N_OEF + 1);

  logic          t_start, t_expire;
  logic [CW-1:0] t_load;
  logic          sel, rden, accept, capture;

  sram_rd_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(t_start), .load(t_load), .expire(t_expire)
  );

  sram_rd_fsm #(.N_ACC(N_ACC), .N_OEF(N_OEF), .N_CEF(N_CEF), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .t_expire(t_expire), .t_start(t_start), .t_load(t_load),
    .sel(sel), .rden(rden), .accept(accept), .capture(capture)
  );

  sram_rd_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
    .req_addr(req_addr), .mem_din(mem_din), .mem_addr(mem_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign mem_en_lo_n = !sel;
  assign mem_en_hi   = sel;
  assign mem_rden_n  = !rden;
  assign mem_wren_n  = 1'b1;

  // Run length of read-enable-high cycles, saturating at the float count.
  logic [GW-1:0] oe_hi_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       oe_hi_q <= GW'(N_OEF);
    else if (!mem_rden_n)             oe_hi_q <= '0;
    else if (oe_hi_q < GW'(N_OEF))    oe_hi_q <= oe_hi_q + GW'(1);
  end

  // R7: bus released for the float count before the next drive
  assert_float_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rden_n) |-> (oe_hi_q >= GW'(N_OEF)));

  // R2: output enabled only with both enables active
  assert_read_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rden_n |-> (!mem_en_lo_n && mem_en_hi));

  // R4: address frozen while the output is enabled
  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rden_n && $past(!mem_rden_n)) |-> $stable(mem_addr));

endmodule

// File: tb/test_sram_rd_seq.sv
module test_sram_rd_seq;

  localparam int CLK_NS = 5;
  localparam int E_ACC = ((15 + CLK_NS - 1) / CLK_NS < 1) ? 1 : (15 + CLK_NS - 1) / CLK_NS;
  localparam int E_OEF = ((7 + CLK_NS - 1) / CLK_NS < 1) ? 1 : (7 + CLK_NS - 1) / CLK_NS;
  localparam int E_CEF = ((8 + CLK_NS - 1) / CLK_NS < 1) ? 1 : (8 + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [16:0] req_addr = '0;
  logic        req_ready;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [16:0] mem_addr;
  logic        mem_en_lo_n, mem_en_hi, mem_rden_n, mem_wren_n;
  logic [7:0]  mem_din = 8'h00;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sram_rd_seq #(.CLK_NS(CLK_NS)) i_sram_rd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_en_lo_n(mem_en_lo_n), .mem_en_hi(mem_en_hi),
    .mem_rden_n(mem_rden_n), .mem_wren_n(mem_wren_n), .mem_din(mem_din)
  );

  function automatic logic [7:0] pat(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'hA5;
  endfunction

  // Memory model: data valid once pins are steady for the access time.
  logic [19:0] prev_pins = '1;
  int age = 0;
  always @(negedge clk) begin
    if ({mem_addr, mem_en_lo_n, mem_en_hi, mem_rden_n} == prev_pins) age++;
    else age = 1;
    prev_pins = {mem_addr, mem_en_lo_n, mem_en_hi, mem_rden_n};
    if (!mem_en_lo_n && mem_en_hi && !mem_rden_n && mem_wren_n && age * CLK_NS >= 15)
      mem_din = pat(mem_addr);
    else
      mem_din = ~pat(mem_addr);
  end

  // Pin monitor, sampling pre-edge values.
  int we_low = 0, addr_moves = 0, ce_drops = 0, oe_run = 0, last_gap = 0;
  logic prev_sel = 1'b0, prev_oe_lo = 1'b0;
  logic [16:0] prev_addr = '0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (!mem_wren_n) we_low++;
      if (!mem_rden_n && prev_oe_lo && mem_addr != prev_addr) addr_moves++;
      if (prev_sel && !(!mem_en_lo_n && mem_en_hi)) ce_drops++;
      if (mem_rden_n) oe_run++;
      else begin
        if (!prev_oe_lo) last_gap = oe_run;
        oe_run = 0;
      end
      prev_sel   = !mem_en_lo_n && mem_en_hi;
      prev_oe_lo = !mem_rden_n;
      prev_addr  = mem_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(mem_en_lo_n == 1'b1, "R1 low-active enable", int'(mem_en_lo_n), 1);
    chk(mem_en_hi == 1'b0,   "R1 high-active enable", int'(mem_en_hi), 0);
    chk(mem_rden_n == 1'b1,  "R1 read enable", int'(mem_rden_n), 1);
    chk(mem_wren_n == 1'b1,  "R1 write enable", int'(mem_wren_n), 1);
    chk(rd_valid == 1'b0,    "R1 valid", int'(rd_valid), 0);
    chk(req_ready == 1'b1,   "R1 ready", int'(req_ready), 1);
  endtask

  // One read; entered and left on a falling edge.
  task automatic t_read(input logic [16:0] a, input bit chained);
    int drops0 = ce_drops;
    int lat = 0, oe_lo = 0;
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a;
    chk(mem_addr == a, "R4 address latched", int'(mem_addr), int'(a));
    chk(!mem_en_lo_n && mem_en_hi, "R2 selected during access", int'(mem_en_hi), 1);
    while (!rd_valid && lat < 50) begin
      if (!mem_rden_n) oe_lo++;
      lat++;
      @(negedge clk);
    end
    chk(lat == E_ACC, "R5 accept to valid", lat, E_ACC);
    chk(oe_lo == E_ACC, "R5 read enable low cycles", oe_lo, E_ACC);
    chk(rd_data == pat(a), "R6 read data", int'(rd_data), int'(pat(a)));
    chk(req_ready == 1'b0 && mem_rden_n == 1'b1, "R7 ready low in gap", int'(req_ready), 0);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R6 single-cycle valid", int'(rd_valid), 0);
    if (chained) begin
      chk(ce_drops == drops0, "R8 enables held across reads", ce_drops, drops0);
      chk(last_gap == E_OEF + 1, "R8 read-enable gap", last_gap, E_OEF + 1);
    end else begin
      chk(last_gap >= E_OEF, "R7 minimum gap", last_gap, E_OEF);
    end
  endtask

  // No request offered: deselect and float.
  task automatic t_release();
    int drops0 = ce_drops;
    int low = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    chk(mem_en_lo_n == 1'b1 && mem_en_hi == 1'b0, "R9 deselected", int'(mem_en_hi), 0);
    while (!req_ready && low < 50) begin
      low++;
      @(negedge clk);
    end
    chk(low == E_CEF, "R9 float wait", low, E_CEF);
    chk(ce_drops == drops0 + 1, "R9 one deselect", ce_drops, drops0 + 1);
    chk(mem_rden_n == 1'b1, "R10 read enable off when ready", int'(mem_rden_n), 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read(17'h00000, 1'b0);
        t_read(17'h1FFFF, 1'b1);
        t_read(17'h0ABCD, 1'b1);
        t_read(17'h15555, 1'b1);
        t_release();
        t_read(17'h000FF, 1'b0);
        t_release();
        repeat (4) @(negedge clk);
        t_reset();
        chk(we_low == 0, "R3 write enable never low", we_low, 0);
        chk(addr_moves == 0, "R4 address stable in access", addr_moves, 0);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule